// File: doc/BRIEF.md
# Priority-preemptive credit-aware output arbiter

This block decides, for one output port of a network router, which virtual channel puts its next flit on the output link in the current cycle. Each virtual channel has its own fixed priority, equal to its index, so the highest index always wins. The decision is taken again for every flit. A higher-priority channel can therefore take the link part way through a lower-priority packet. The interrupted channel carries on later from where it stopped.

A channel may only send when the buffer for that channel in the neighbouring router has free space. The block tracks this space with one credit counter per virtual channel. A counter goes down by one for each flit granted on its channel and up by one for each credit the neighbour returns. When the highest-priority requester has no credit, it is passed over and the link goes to the next requester that can send. Buffer storage and route computation live outside this block.

Top module: `vc_out_arbiter`

## Requirements
- R1: In every cycle the grant goes to the requesting channel with the highest index that holds at least one credit. The grant is combinational in the current requests and credit counts.
- R2: `grant_o` is one-hot or zero. At most one flit is sent per cycle.
- R3: When no requesting channel holds credit, `grant_o` is zero and `link_valid_o` is low. Otherwise `link_valid_o` is high and `grant_vc_o` gives the index of the granted channel.
- R4: After reset every channel holds BUF_DEPTH credits (3 by default). With its request held and no credit returned, a channel is granted exactly that many times.
- R5: A grant on a channel without a credit return in the same cycle lowers that channel's credit count by one from the next cycle on.
- R6: A credit return on a channel without a grant in the same cycle raises that channel's count by one, and the channel can send again from the next cycle on.
- R7: A grant and a credit return on the same channel in the same cycle leave its count unchanged.
- R8: A credit return on a channel that already holds BUF_DEPTH credits is ignored. The count never exceeds BUF_DEPTH and never goes below zero.
- R9: A requesting channel with zero credits is skipped in favour of the highest lower-index requester that has credit.
- R10: A higher-priority request that arrives while a lower channel is mid-packet takes the link at once. When it drops, the lower channel resumes with the credits it had left.

Each channel has its own bit in `req_i`, `credit_ret_i` and `grant_o`, with bit i belonging to channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NUM_VC | Per-channel request for the link; bit i is channel i, priority i |
| credit_ret_i | input | NUM_VC | Per-channel credit returned by the neighbour this cycle |
| grant_o | output | NUM_VC | One-hot grant of the channel sending this cycle |
| link_valid_o | output | 1 | A flit is sent on the link this cycle |
| grant_vc_o | output | $clog2(NUM_VC) | Index of the granted channel, meaningful when link_valid_o is high |

## Verification
With all credits kept full, every one of the 255 non-zero request patterns is applied. This shows whether the priority picker always takes the top set bit. The credits stay full because each grant is paired with a credit return on the same channel, which also exercises the same-cycle hold rule.

A sustained all-channel request with no returns drains the channels from the top down, three flits each, and then ends with an idle link. This tells the credit counting apart from the priority logic. It also shows that a drained channel is skipped. Single-channel returns, returns into a full counter, a preemption-and-resume sequence, and a long pseudo-random run of requests and returns complete the coverage. The random run is checked against an arithmetic credit model kept in the bench.

// File: rtl/vc_arb_pkg.sv
package vc_arb_pkg;
  localparam int unsigned DEF_NUM_VC    = 8;
  localparam int unsigned DEF_BUF_DEPTH = 3;

  typedef enum logic [1:0] {
    CR_HOLD = 2'd0,
    CR_DEC  = 2'd1,
    CR_INC  = 2'd2
  } cr_op_e;
endpackage

// File: rtl/vc_rst_sync.sv
module vc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/vc_credit_ctr.sv
module vc_credit_ctr
  import vc_arb_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_BUF_DEPTH,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic          ret_i,
  output logic          avail_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  cr_op_e        op;

  always_comb begin
    op = CR_HOLD;
    if (take_i && !ret_i && (cnt_q != '0)) begin
      op = CR_DEC;
    end else if (ret_i && !take_i && (cnt_q != FULL)) begin
      op = CR_INC;
    end
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    case (op)
      CR_DEC: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - 1'b1;
      end
      CR_INC: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
      end
      default: begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= FULL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign avail_o = (cnt_q != '0);
  assign count_o = cnt_q;
endmodule

// File: rtl/vc_prio_pick.sv
module vc_prio_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  elig_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  logic [IW-1:0] idx;
  logic          found;

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (elig_i[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end

  assign gnt_o   = found ? (N'(1) << idx) : '0;
  assign idx_o   = idx;
  assign valid_o = found;
endmodule

// File: rtl/vc_out_arbiter.sv
module vc_out_arbiter
  import vc_arb_pkg::*;
#(
  parameter int unsigned NUM_VC    = DEF_NUM_VC,
  parameter int unsigned BUF_DEPTH = DEF_BUF_DEPTH,
  parameter int unsigned IW        = $clog2(NUM_VC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VC-1:0] req_i,
  input  logic [NUM_VC-1:0] credit_ret_i,
  output logic [NUM_VC-1:0] grant_o,
  output logic              link_valid_o,
  output logic [IW-1:0]     grant_vc_o
);
  localparam int unsigned CW = $clog2(BUF_DEPTH + 1);

  logic                 rst_sync_n;
  logic [NUM_VC-1:0]    avail;
  logic [NUM_VC-1:0]    elig;
  logic [NUM_VC-1:0]    gnt;
  logic [NUM_VC*CW-1:0] cred_flat;

  vc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar v = 0; v < int'(NUM_VC); v++) begin : g_vc
    vc_credit_ctr #(
      .DEPTH (BUF_DEPTH),
      .CW    (CW)
    ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .take_i  (gnt[v]),
      .ret_i   (credit_ret_i[v]),
      .avail_o (avail[v]),
      .count_o (cred_flat[v*CW +: CW])
    );
  end

  assign elig = req_i & avail;

  vc_prio_pick #(
    .N  (NUM_VC),
    .IW (IW)
  ) u_pick (
    .elig_i  (elig),
    .gnt_o   (gnt),
    .idx_o   (grant_vc_o),
    .valid_o (link_valid_o)
  );

  assign grant_o = gnt;
endmodule

// File: rtl/vc_out_arbiter_chk.sv
module vc_out_arbiter_chk #(
  parameter int unsigned NUM_VC    = 8,
  parameter int unsigned BUF_DEPTH = 3,
  parameter int unsigned IW        = $clog2(NUM_VC),
  parameter int unsigned CW        = $clog2(BUF_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_VC-1:0]    req,
  input logic [NUM_VC-1:0]    ret,
  input logic [NUM_VC-1:0]    grant,
  input logic                 link_valid,
  input logic [IW-1:0]        grant_vc,
  input logic [NUM_VC-1:0]    avail,
  input logic [NUM_VC*CW-1:0] cred_flat
);
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_valid_iff_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid == (grant != '0));

  assert_index_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> grant[grant_vc]);

  for (genvar i = 0; i < int'(NUM_VC); i++) begin : g_i
    assert_grant_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> (req[i] && avail[i]));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cred_flat[i*CW +: CW] <= CW'(BUF_DEPTH));

    assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && !ret[i]) |=> (cred_flat[i*CW +: CW] == $past(cred_flat[i*CW +: CW]) - 1'b1));

    assert_increment_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret[i] && !grant[i] && (cred_flat[i*CW +: CW] < CW'(BUF_DEPTH)))
        |=> (cred_flat[i*CW +: CW] == $past(cred_flat[i*CW +: CW]) + 1'b1));

    assert_simul_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && ret[i]) |=> $stable(cred_flat[i*CW +: CW]));

    for (genvar j = i + 1; j < int'(NUM_VC); j++) begin : g_j
      assert_no_higher_eligible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant[i] |-> !(req[j] && avail[j]));
    end
  end
endmodule

bind vc_out_arbiter vc_out_arbiter_chk #(
  .NUM_VC    (NUM_VC),
  .BUF_DEPTH (BUF_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req        (req_i),
  .ret        (credit_ret_i),
  .grant      (grant_o),
  .link_valid (link_valid_o),
  .grant_vc   (grant_vc_o),
  .avail      (avail),
  .cred_flat  (cred_flat)
);

// File: tb/vc_out_arbiter_tb.sv
module vc_out_arbiter_tb;
  localparam int NV  = 8;
  localparam int DEP = 3;

  logic          clk;
  logic          rst_n;
  logic [NV-1:0] req_i;
  logic [NV-1:0] credit_ret_i;
  logic [NV-1:0] grant_o;
  logic          link_valid_o;
  logic [2:0]    grant_vc_o;

  int n_vec;
  int n_bad;
  int cred [NV];

  vc_out_arbiter u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .credit_ret_i (credit_ret_i),
    .grant_o      (grant_o),
    .link_valid_o (link_valid_o),
    .grant_vc_o   (grant_vc_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_idx(input logic [NV-1:0] r);
    int e;
    e = -1;
    for (int i = 0; i < NV; i++) begin
      if (r[i] && cred[i] > 0) e = i;
    end
    return e;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_i = '0;
    credit_ret_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NV; i++) cred[i] = DEP;
  endtask

  task automatic step(input logic [NV-1:0] r, input logic [NV-1:0] rt,
                      input bit refund, input string tag);
    int e;
    logic [NV-1:0] eg;
    logic ev;
    @(negedge clk);
    e  = exp_idx(r);
    ev = (e >= 0);
    eg = ev ? (NV'(1) << e) : '0;
    req_i = r;
    credit_ret_i = refund ? (rt | eg) : rt;
    #1;
    n_vec++;
    if (grant_o !== eg || link_valid_o !== ev || (ev && grant_vc_o !== 3'(e))) begin
      n_bad++;
      $display("FAIL %s: grant=%b valid=%b idx=%0d expected grant=%b valid=%b idx=%0d",
               tag, grant_o, link_valid_o, grant_vc_o, eg, ev, e);
    end
    for (int i = 0; i < NV; i++) begin
      if (eg[i] && !credit_ret_i[i]) cred[i] = cred[i] - 1;
      else if (credit_ret_i[i] && !eg[i] && cred[i] < DEP) cred[i] = cred[i] + 1;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    n_vec = 0;
    n_bad = 0;
    rst_n = 1'b0;
    req_i = '0;
    credit_ret_i = '0;
    do_reset();

    // R3: idle after reset
    step('0, '0, 1'b0, "R3 idle after reset");

    // R1 and R7: sweep all request patterns, credits refunded in the same cycle
    for (int p = 1; p < 256; p++) step(NV'(p), '0, 1'b1, "R1 R7 sweep");

    // R4 R5 R9 R3: drain from the top, three flits each, then idle
    for (int k = 0; k < NV * DEP + 3; k++) step('1, '0, 1'b0, "R4 R5 R9 drain");

    // R6: single return on VC3 re-enables it for one flit
    step('0, 8'h08, 1'b0, "R6 return idle");
    step('1, '0, 1'b0, "R6 resume VC3");
    step('1, '0, 1'b0, "R3 drained again");

    // R8: returns into a full counter are ignored
    do_reset();
    step('0, 8'h01, 1'b0, "R8 extra return");
    step('0, 8'h01, 1'b0, "R8 extra return");
    for (int k = 0; k < DEP + 2; k++) step(8'h01, '0, 1'b0, "R8 count capped");

    // R10: preemption mid-packet and resume
    do_reset();
    step(8'h04, '0, 1'b0, "R10 VC2 starts");
    step(8'h24, '0, 1'b0, "R10 VC5 preempts");
    step(8'h24, '0, 1'b0, "R10 VC5 continues");
    step(8'h04, '0, 1'b0, "R10 VC2 resumes");
    step(8'h04, '0, 1'b0, "R10 VC2 last credit");
    step(8'h04, '0, 1'b0, "R10 VC2 out of credit");
    // R9: VC5 has one credit left, then VC4 takes over
    step(8'h30, '0, 1'b0, "R9 VC5 last");
    step(8'h30, '0, 1'b0, "R9 skip VC5");

    // R1 R5 R6 R8: pseudo-random traffic against the model
    lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[7:0], lf[15:8] & {lf[3:0], lf[7:4]}, 1'b0, "R1 R5 R6 R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule